// File: doc/BRIEF.md
# Interleaving Sample-Timestamp Stream Packer

The packer accepts captured segments of 32 samples, each carrying a 32-bit data word and a 64-bit timestamp, and turns every stored segment into a single 32-bit word stream for one host-bound queue. Every sample leaves as a group of three consecutive words: the data word, then the upper timestamp half, then the lower half. The host pairs a data word with its timestamp purely from its position in the stream.

Acquisition and output are decoupled by a two-segment ping-pong store. The write side has no ready signal and never stalls: a sample presented with `in_valid` is taken in the same cycle. The output side uses a valid/ready handshake, moves one word per cycle at most, and flags the final word of each segment. When both banks still hold undrained segments, a newly started segment is discarded whole and a sticky overflow flag is raised.

The write side is a state machine with states W_IDLE (waiting for a start-marked sample), W_FILL (storing samples 2 to 32 into a free bank) and W_DROP (discarding a segment that found no free bank). Transitions: W_IDLE to W_FILL on a start-marked sample when the target bank is free; W_IDLE to W_DROP on a start-marked sample when it is full; W_FILL and W_DROP back to W_IDLE on the 32nd sample. The read side has states R_IDLE (no stored segment), R_DATA, R_TSHI and R_TSLO (presenting data, upper and lower timestamp words). Transitions: R_IDLE to R_DATA when the read bank is full; R_DATA to R_TSHI and R_TSHI to R_TSLO on an accepted word; R_TSLO to R_DATA on an accepted word for samples 1 to 31, and R_TSLO to R_IDLE on the accepted 96th word, which also frees the bank.

Top module: `seg_triplet_packer`

## Requirements
- R1: A segment begins with a sample that has `in_valid` and `in_start` both high while the write side is idle; valid samples without `in_start` while idle are ignored and produce no output.
- R2: Each stored segment yields exactly 96 output words; for sample i (0..31) word 3i is the data word, word 3i+1 is timestamp bits 63:32 and word 3i+2 is timestamp bits 31:0.
- R3: `out_last` is high with the 96th word of a segment and low with every other word.
- R4: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` stay unchanged in the next cycle.
- R5: The write side never stalls: two complete segments are stored even when `out_ready` is held low, and samples may arrive with idle cycles between them.
- R6: A segment started while both banks hold undrained segments is dropped in full and `ovf_sticky` goes high and stays high until reset; the two stored segments are unaffected.
- R7: A synchronous reset (`rst` high at a clock edge) empties both banks, clears `ovf_sticky` and leaves `out_valid` low.
- R8: Stored segments are sent out in the order in which they were captured.
- R9: `out_valid` is low whenever no complete segment is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A sample is presented this cycle |
| in_start | input | 1 | The presented sample is the first of a segment |
| in_data | input | 32 | Sample data word |
| in_ts | input | 64 | Sample timestamp |
| out_valid | output | 1 | Output word is valid |
| out_ready | input | 1 | Consumer accepts the output word |
| out_data | output | 32 | Output word |
| out_last | output | 1 | Output word is the last of its segment |
| ovf_sticky | output | 1 | A segment was dropped since reset |

## Verification
The checker assumes the capture side sends exactly 32 valid samples per segment with `in_start` on the first one only, so that the output word count modulo 96 lines up with `out_last`, and that `out_ready` is never used to infer anything from the write side. The bench keeps to this: every segment it writes is a full 32-sample burst started by one marked sample, with idle gaps only between samples, and the stray unmarked samples it injects arrive only while the write side is idle. Output-side readiness patterns (always ready, alternating, one cycle in three, long initial stall) exercise the hold rule without ever altering the capture framing.

// File: rtl/stp_pkg.sv
package stp_pkg;
    typedef enum logic [1:0] {
        W_IDLE = 2'd0,
        W_FILL = 2'd1,
        W_DROP = 2'd2
    } wr_state_t;

    typedef enum logic [1:0] {
        R_IDLE = 2'd0,
        R_DATA = 2'd1,
        R_TSHI = 2'd2,
        R_TSLO = 2'd3
    } rd_state_t;
endpackage

// File: rtl/seg_bank_store.sv
module seg_bank_store #(
    parameter int SAMPLES = 32,
    parameter int DW      = 32,
    parameter int TW      = 64,
    localparam int IW     = $clog2(SAMPLES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          wr_bank,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic [TW-1:0] wr_ts,
    input  logic          seg_done,
    input  logic          rd_bank,
    input  logic [IW-1:0] rd_idx,
    input  logic          rd_release,
    output logic [1:0]    full,
    output logic [DW-1:0] rd_data,
    output logic [TW-1:0] rd_ts
);
    localparam int DEPTH = 2 * SAMPLES;

    logic [DW-1:0] dmem [DEPTH];
    logic [TW-1:0] tmem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            dmem[{wr_bank, wr_idx}] <= wr_data;
            tmem[{wr_bank, wr_idx}] <= wr_ts;
        end
    end

    assign rd_data = dmem[{rd_bank, rd_idx}];
    assign rd_ts   = tmem[{rd_bank, rd_idx}];

    for (genvar b = 0; b < 2; b++) begin : g_bank
        always_ff @(posedge clk) begin
            if (rst) begin
                full[b] <= 1'b0;
            end else if (seg_done && (wr_bank == 1'(b))) begin
                full[b] <= 1'b1;
            end else if (rd_release && (rd_bank == 1'(b))) begin
                full[b] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/seg_write_fsm.sv
module seg_write_fsm
    import stp_pkg::*;
#(
    parameter int SAMPLES = 32,
    localparam int IW     = $clog2(SAMPLES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic          in_start,
    input  logic [1:0]    full,
    output logic          wr_en,
    output logic          wr_bank,
    output logic [IW-1:0] wr_idx,
    output logic          seg_done,
    output logic          ovf
);
    localparam logic [IW-1:0] LAST = IW'(SAMPLES - 1);

    wr_state_t state, state_nxt;
    logic      drop_start;

    always_ff @(posedge clk) begin
        if (rst) state <= W_IDLE;
        else     state <= state_nxt;
    end

    always_comb begin
        state_nxt  = state;
        wr_en      = 1'b0;
        seg_done   = 1'b0;
        drop_start = 1'b0;
        unique case (state)
            W_IDLE: begin
                if (in_valid && in_start) begin
                    if (full[wr_bank]) begin
                        drop_start = 1'b1;
                        state_nxt  = W_DROP;
                    end else begin
                        wr_en      = 1'b1;
                        state_nxt  = W_FILL;
                    end
                end
            end
            W_FILL: begin
                wr_en = in_valid;
                if (in_valid && wr_idx == LAST) begin
                    seg_done  = 1'b1;
                    state_nxt = W_IDLE;
                end
            end
            W_DROP: begin
                if (in_valid && wr_idx == LAST) state_nxt = W_IDLE;
            end
            default: state_nxt = W_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_idx  <= '0;
            wr_bank <= 1'b0;
            ovf     <= 1'b0;
        end else begin
            if (state == W_IDLE)
                wr_idx <= (in_valid && in_start) ? IW'(1) : '0;
            else if (in_valid)
                wr_idx <= (wr_idx == LAST) ? '0 : wr_idx + 1'b1;
            if (seg_done)   wr_bank <= ~wr_bank;
            if (drop_start) ovf     <= 1'b1;
        end
    end
endmodule

// File: rtl/triplet_read_fsm.sv
module triplet_read_fsm
    import stp_pkg::*;
#(
    parameter int SAMPLES = 32,
    parameter int DW      = 32,
    parameter int TW      = 64,
    localparam int IW     = $clog2(SAMPLES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    full,
    input  logic          out_ready,
    input  logic [DW-1:0] rd_data,
    input  logic [TW-1:0] rd_ts,
    output logic          rd_bank,
    output logic [IW-1:0] rd_idx,
    output logic          rd_release,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    output logic          out_last
);
    localparam logic [IW-1:0] LAST = IW'(SAMPLES - 1);

    rd_state_t state, state_nxt;
    logic      last_smp;

    assign last_smp = (rd_idx == LAST);

    always_ff @(posedge clk) begin
        if (rst) state <= R_IDLE;
        else     state <= state_nxt;
    end

    always_comb begin
        state_nxt  = state;
        rd_release = 1'b0;
        out_valid  = 1'b0;
        out_data   = '0;
        out_last   = 1'b0;
        unique case (state)
            R_IDLE: begin
                if (full[rd_bank]) state_nxt = R_DATA;
            end
            R_DATA: begin
                out_valid = 1'b1;
                out_data  = rd_data;
                if (out_ready) state_nxt = R_TSHI;
            end
            R_TSHI: begin
                out_valid = 1'b1;
                out_data  = rd_ts[TW-1:TW-DW];
                if (out_ready) state_nxt = R_TSLO;
            end
            R_TSLO: begin
                out_valid = 1'b1;
                out_data  = rd_ts[DW-1:0];
                out_last  = last_smp;
                if (out_ready) begin
                    rd_release = last_smp;
                    state_nxt  = last_smp ? R_IDLE : R_DATA;
                end
            end
            default: state_nxt = R_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_idx  <= '0;
            rd_bank <= 1'b0;
        end else if (state == R_TSLO && out_ready) begin
            rd_idx <= last_smp ? '0 : rd_idx + 1'b1;
            if (last_smp) rd_bank <= ~rd_bank;
        end
    end
endmodule

// File: rtl/seg_triplet_packer.sv
module seg_triplet_packer #(
    parameter int SAMPLES = 32,
    parameter int DW      = 32,
    parameter int TW      = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic          in_start,
    input  logic [DW-1:0] in_data,
    input  logic [TW-1:0] in_ts,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [DW-1:0] out_data,
    output logic          out_last,
    output logic          ovf_sticky
);
    localparam int IW = $clog2(SAMPLES);

    logic          wr_en, wr_bank, seg_done;
    logic [IW-1:0] wr_idx, rd_idx;
    logic          rd_bank, rd_release;
    logic [1:0]    full;
    logic [DW-1:0] rd_data;
    logic [TW-1:0] rd_ts;

    seg_write_fsm #(.SAMPLES(SAMPLES)) u_wr (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_start(in_start),
        .full(full), .wr_en(wr_en), .wr_bank(wr_bank), .wr_idx(wr_idx),
        .seg_done(seg_done), .ovf(ovf_sticky)
    );

    seg_bank_store #(.SAMPLES(SAMPLES), .DW(DW), .TW(TW)) u_store (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_bank(wr_bank),
        .wr_idx(wr_idx), .wr_data(in_data), .wr_ts(in_ts),
        .seg_done(seg_done), .rd_bank(rd_bank), .rd_idx(rd_idx),
        .rd_release(rd_release), .full(full), .rd_data(rd_data),
        .rd_ts(rd_ts)
    );

    triplet_read_fsm #(.SAMPLES(SAMPLES), .DW(DW), .TW(TW)) u_rd (
        .clk(clk), .rst(rst), .full(full), .out_ready(out_ready),
        .rd_data(rd_data), .rd_ts(rd_ts), .rd_bank(rd_bank),
        .rd_idx(rd_idx), .rd_release(rd_release), .out_valid(out_valid),
        .out_data(out_data), .out_last(out_last)
    );
endmodule

// File: rtl/seg_packer_checker.sv
module seg_packer_checker #(
    parameter int SAMPLES = 32,
    parameter int DW      = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          out_valid,
    input logic          out_ready,
    input logic [DW-1:0] out_data,
    input logic          out_last,
    input logic          ovf_sticky
);
    localparam int WORDS = 3 * SAMPLES;
    localparam int CW    = $clog2(WORDS);

    logic [CW-1:0] wcnt;

    always_ff @(posedge clk) begin
        if (rst)
            wcnt <= '0;
        else if (out_valid && out_ready)
            wcnt <= (wcnt == CW'(WORDS - 1)) ? '0 : wcnt + 1'b1;
    end

    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last)); // R4

    AST_LAST_POSITION: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_last == (wcnt == CW'(WORDS - 1)))); // R3

    AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid); // R2

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        ovf_sticky |=> ovf_sticky); // R6

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> !out_valid && !ovf_sticky); // R7
endmodule

bind seg_triplet_packer seg_packer_checker #(.SAMPLES(SAMPLES), .DW(DW)) u_chk (
    .clk(clk), .rst(rst), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last), .ovf_sticky(ovf_sticky)
);

// File: tb/seg_triplet_packer_tb.sv
module seg_triplet_packer_tb;
    localparam int SAMPLES = 32;
    localparam int WORDS   = 3 * SAMPLES;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_start = 1'b0;
    logic [31:0] in_data = '0;
    logic [63:0] in_ts = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_data;
    logic        out_last;
    logic        ovf_sticky;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    seg_triplet_packer u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_start(in_start),
        .in_data(in_data), .in_ts(in_ts), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
        .ovf_sticky(ovf_sticky)
    );

    // Row: {segment base[15:0], ready mode[1:0], gap flag}
    localparam logic [18:0] VEC [4] = '{
        {16'h1111, 2'd0, 1'b0},
        {16'h2222, 2'd1, 1'b1},
        {16'h3333, 2'd2, 1'b0},
        {16'h4444, 2'd3, 1'b1}
    };

    function automatic logic [31:0] smp_data(input logic [15:0] b, input int i);
        return {b, 8'h00, 8'(i)};
    endfunction
    function automatic logic [63:0] smp_ts(input logic [15:0] b, input int i);
        return {8'hE1, 8'(i), b, b ^ 16'h5A5A, 8'h7C, 8'(i)};
    endfunction
    function automatic logic [31:0] exp_word(input logic [15:0] b, input int k);
        logic [63:0] t;
        t = smp_ts(b, k / 3);
        case (k % 3)
            0:       return smp_data(b, k / 3);
            1:       return t[63:32];
            default: return t[31:0];
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic write_seg(input logic [15:0] b, input bit gaps);
        for (int i = 0; i < SAMPLES; i++) begin
            if (gaps && i[0]) begin
                @(negedge clk);
                in_valid = 1'b0;
                in_start = 1'b0;
            end
            @(negedge clk);
            in_valid = 1'b1;
            in_start = (i == 0);
            in_data  = smp_data(b, i);
            in_ts    = smp_ts(b, i);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_start = 1'b0;
    endtask

    task automatic drain_seg(input logic [15:0] b, input logic [1:0] mode,
                             input string req);
        int k = 0, cyc = 0, bad = 0, lbad = 0;
        logic [31:0] fa = '0, fe = '0;
        bit rdy;
        while (k < WORDS && cyc < 5000) begin
            @(negedge clk);
            cyc++;
            case (mode)
                2'd0:    rdy = 1'b1;
                2'd1:    rdy = cyc[0];
                2'd2:    rdy = (cyc % 3 == 0);
                default: rdy = (cyc > 20);
            endcase
            out_ready = rdy;
            #1;
            if (out_valid && rdy) begin
                if (out_data !== exp_word(b, k)) begin
                    if (bad == 0) begin fa = out_data; fe = exp_word(b, k); end
                    bad++;
                end
                if (out_last !== (k == WORDS - 1)) lbad++;
                k++;
            end
        end
        @(negedge clk);
        out_ready = 1'b0;
        check(bad == 0 && k == WORDS, req, "segment words/order", 64'(fa), 64'(fe));
        check(lbad == 0, "R3", "last flag placement", 64'(lbad), 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R9", "idle out_valid after reset", 64'(out_valid), 0);
        check(ovf_sticky == 1'b0, "R7", "ovf after reset", 64'(ovf_sticky), 0);

        // Table walk: R2/R5 under several readiness patterns
        for (int r = 0; r < 4; r++) begin
            fork
                write_seg(VEC[r][18:3], VEC[r][0]);
                drain_seg(VEC[r][18:3], VEC[r][2:1], "R2");
            join
        end

        // R1: stray unmarked samples while idle are ignored
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_start = 1'b0;
            in_data  = 32'hBAD0_0000 + 32'(i);
        end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (4) @(negedge clk);
        check(out_valid == 1'b0, "R1", "no output from unmarked samples", 64'(out_valid), 0);
        fork
            write_seg(16'h5555, 1'b0);
            drain_seg(16'h5555, 2'd0, "R1");
        join

        // R5/R6/R8/R4: stalled output, two stored, third dropped
        out_ready = 1'b0;
        write_seg(16'hA0A0, 1'b0);
        write_seg(16'hB0B0, 1'b1);
        write_seg(16'hC0C0, 1'b0);
        repeat (3) @(negedge clk);
        check(ovf_sticky == 1'b1, "R6", "overflow flag on third segment", 64'(ovf_sticky), 1);
        begin
            int hold_bad = 0;
            for (int i = 0; i < 6; i++) begin
                @(negedge clk);
                if (!(out_valid && out_data == exp_word(16'hA0A0, 0) && !out_last)) hold_bad++;
            end
            check(hold_bad == 0, "R4", "word held while stalled", 64'(out_data), 64'(exp_word(16'hA0A0, 0)));
        end
        drain_seg(16'hA0A0, 2'd1, "R8");
        drain_seg(16'hB0B0, 2'd0, "R5");
        repeat (10) @(negedge clk);
        check(out_valid == 1'b0, "R6", "dropped segment not emitted", 64'(out_valid), 0);
        check(ovf_sticky == 1'b1, "R6", "overflow stays set", 64'(ovf_sticky), 1);

        // R7: reset with a stored segment and overflow set
        write_seg(16'hD0D0, 1'b0);
        repeat (2) @(negedge clk);
        check(out_valid == 1'b1, "R9", "stored segment offered", 64'(out_valid), 1);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R7", "buffer emptied by reset", 64'(out_valid), 0);
        check(ovf_sticky == 1'b0, "R7", "overflow cleared by reset", 64'(ovf_sticky), 0);
        fork
            write_seg(16'hE0E0, 1'b0);
            drain_seg(16'hE0E0, 2'd2, "R7");
        join

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule